// File: doc/BRIEF.md
# AES-128 Round Key Schedule Generator

This block turns a 128-bit cipher key into the complete AES-128 key schedule: the initial whitening key followed by ten round keys, 44 words of 32 bits in all. The key is captured while reset is held. After reset is released the block builds exactly one new schedule word per clock, so the full schedule is ready 40 clocks later. A `ready` flag tells the cipher pipeline when it may start.

Round keys are read through an indexed port. With the direction select low, index r gives round key r (encryption order). With it high, index r gives round key 10-r, so a decryption datapath can count upward from 0 and still receive the last expanded key first. The read port is combinational and returns zero whenever the schedule is incomplete or the index is out of range.

Top module: `aes128_key_sched`

## Requirements
- R1: `key_in` is captured on every clock edge while `rst` is high; changes to `key_in` after `rst` falls have no effect on the schedule.
- R2: `ready` is 0 during reset and for the first 39 rising edges after `rst` falls, and becomes 1 on the 40th rising edge after release.
- R3: Once high, `ready` stays 1 until `rst` is asserted again; the first rising edge with `rst` high clears it.
- R4: Schedule words 4..43 follow the AES-128 rule w[i] = w[i-4] ^ t. When i is a multiple of 4, t = SubWord(RotWord(w[i-1])) ^ {rcon,24'h0}, with rcon stepping 01,02,04,08,10,20,40,80,1B,36. Otherwise t = w[i-1].
- R5: With `dec_sel` = 0 and `rd_idx` = r (0..10), `rk_out` = {w[4r], w[4r+1], w[4r+2], w[4r+3]}, with w[4r] in bits 127:96. Round 0 equals the captured key.
- R6: With `dec_sel` = 1 and `rd_idx` = r (0..10), `rk_out` returns round key 10-r, so index 0 gives the last round key.
- R7: With `rd_idx` in 11..15, `rk_out` is all zeros in either direction.
- R8: While `ready` is 0, `rk_out` is all zeros for every index and direction.
- R9: Schedule word 0 is `key_in[127:96]` and word 3 is `key_in[31:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Active-high synchronous reset; the key is captured while it is high |
| key_in | input | 128 | Cipher key |
| dec_sel | input | 1 | 0 = forward round order, 1 = reversed round order |
| rd_idx | input | 4 | Round index for the read port |
| rk_out | output | 128 | Selected round key, zero when not ready or index invalid |
| ready | output | 1 | High once the whole schedule has been built |

## Verification
The assertions assume `rst` is high at the first clock edge, so the expansion counter and the flag start from a known state. They also assume `rd_idx` and `dec_sel` are changed only between edges. The bench meets both conditions by holding reset for several cycles at the start and driving every input at the falling edge. Each key run holds reset for at least two cycles before release, and the bench deliberately scrambles `key_in` during expansion to show it is ignored.

// File: rtl/aes128_key_sched.sv
module aes128_key_sched #(
  parameter int NR = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [127:0] key_in,
  input  logic         dec_sel,
  input  logic [3:0]   rd_idx,
  output logic [127:0] rk_out,
  output logic         ready
);
  localparam int NW = 4 * (NR + 1);
  localparam int IW = $clog2(NW + 1);
  localparam int RW = 4;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq, inv;
    sq  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  logic [31:0]   w [NW];
  logic [IW-1:0] cnt;
  logic [7:0]    rcon;

  wire [31:0] prev   = w[cnt - IW'(1)];
  wire [31:0] back   = w[cnt - IW'(4)];
  wire        is_rot = (cnt[1:0] == 2'b00);
  wire [31:0] rot    = {prev[23:0], prev[31:24]};
  wire [31:0] subw   = {sbox(rot[31:24]), sbox(rot[23:16]), sbox(rot[15:8]), sbox(rot[7:0])};
  wire [31:0] tmp    = is_rot ? (subw ^ {rcon, 24'h0}) : prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      w[0]  <= key_in[127:96];
      w[1]  <= key_in[95:64];
      w[2]  <= key_in[63:32];
      w[3]  <= key_in[31:0];
      cnt   <= IW'(4);
      rcon  <= 8'h01;
      ready <= 1'b0;
    end else if (cnt != IW'(NW)) begin
      w[cnt] <= back ^ tmp;
      cnt    <= cnt + IW'(1);
      if (is_rot) rcon <= {rcon[6:0], 1'b0} ^ (rcon[7] ? 8'h1b : 8'h00);
      if (cnt == IW'(NW - 1)) ready <= 1'b1;
    end
  end

  wire [RW-1:0] sel   = dec_sel ? (RW'(NR) - rd_idx) : rd_idx;
  wire          valid = (rd_idx <= RW'(NR));
  wire [IW-1:0] base  = IW'({sel, 2'b00});

  assign rk_out = (ready && valid)
                ? {w[base], w[base + IW'(1)], w[base + IW'(2)], w[base + IW'(3)]}
                : 128'h0;
endmodule

module aes128_key_sched_chk #(
  parameter int NR = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         dec_sel,
  input logic [3:0]   rd_idx,
  input logic [127:0] rk_out,
  input logic         ready
);
  localparam int LIM = 4 * NR;
  logic [7:0] since;

  always_ff @(posedge clk) begin
    if (rst) since <= 8'd0;
    else if (since != 8'(LIM)) since <= since + 8'd1;
  end

  p_ready_timing_r2: assert property (@(posedge clk) disable iff (rst)
    ready == (since == 8'(LIM)));

  p_clear_on_reset_r3: assert property (@(posedge clk)
    rst |=> !ready);

  p_ready_holds_r3: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (rk_out == 128'h0));

  p_bad_idx_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_idx > 4'(NR)) |-> (rk_out == 128'h0));

  p_read_stable_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(ready) && ready && $stable(rd_idx) && $stable(dec_sel)) |-> $stable(rk_out));
endmodule

bind aes128_key_sched aes128_key_sched_chk #(.NR(NR)) u_chk (
  .clk(clk), .rst(rst), .dec_sel(dec_sel), .rd_idx(rd_idx),
  .rk_out(rk_out), .ready(ready)
);

// File: tb/aes128_key_sched_tb.sv
module aes128_key_sched_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] key_in = '0;
  logic         dec_sel = 1'b0;
  logic [3:0]   rd_idx = 4'd0;
  logic [127:0] rk_out;
  logic         ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] ew [44];

  always #10 clk = ~clk;

  aes128_key_sched u_dut (
    .clk(clk), .rst(rst), .key_in(key_in), .dec_sel(dec_sel),
    .rd_idx(rd_idx), .rk_out(rk_out), .ready(ready)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (acc[i]) acc = acc ^ (16'h11b << (i - 8));
    return acc[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    for (int b = 1; b < 256; b++) if (fmul(a, 8'(b)) == 8'h01) inv = 8'(b);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (((8'h63) >> i) & 1);
    return s;
  endfunction

  task automatic model(input logic [127:0] k);
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) ew[i] = k[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = ew[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {ref_sbox(t[31:24]), ref_sbox(t[23:16]), ref_sbox(t[15:8]), ref_sbox(t[7:0])};
        t = t ^ {rc, 24'h0};
        rc = (rc == 8'h80) ? 8'h1b : 8'(rc << 1);
      end
      ew[i] = ew[i-4] ^ t;
    end
  endtask

  function automatic logic [127:0] exp_rk(input int r);
    return {ew[4*r], ew[4*r+1], ew[4*r+2], ew[4*r+3]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_rk(input bit d, input int r);
    @(negedge clk);
    dec_sel = d;
    rd_idx  = 4'(r);
    #2;
  endtask

  task automatic run_key(input logic [127:0] k);
    model(k);
    @(negedge clk);
    rst = 1'b1;
    key_in = k;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b0, "R2 ready low in reset", 128'(ready), 128'h0);
    rst = 1'b0;
    key_in = ~k;
    repeat (39) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b0, "R2 ready low after 39 edges", 128'(ready), 128'h0);
    dec_sel = 1'b0; rd_idx = 4'd0; #2;
    chk(rk_out == 128'h0, "R8 zero before ready", rk_out, 128'h0);
    @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1, "R2 ready high at edge 40", 128'(ready), 128'h1);
    for (int r = 0; r <= 10; r++) begin
      read_rk(1'b0, r);
      chk(rk_out == exp_rk(r), "R5/R4/R1 forward round key", rk_out, exp_rk(r));
      read_rk(1'b1, r);
      chk(rk_out == exp_rk(10 - r), "R6 reverse round key", rk_out, exp_rk(10 - r));
    end
    for (int r = 11; r < 16; r++) begin
      read_rk(r[0], r);
      chk(rk_out == 128'h0, "R7 out of range index", rk_out, 128'h0);
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1, "R3 ready holds", 128'(ready), 128'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b0, "R2 reset state ready", 128'(ready), 128'h0);
    chk(rk_out == 128'h0, "R8 reset state output", rk_out, 128'h0);

    run_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    read_rk(1'b0, 0);
    chk(rk_out[127:96] == 32'h2b7e1516, "R9 word 0 position", rk_out, 128'h2b7e1516);
    read_rk(1'b0, 1);
    chk(rk_out == 128'ha0fafe1788542cb123a339392a6c7605, "R4 round 1 vector", rk_out, 128'ha0fafe1788542cb123a339392a6c7605);
    read_rk(1'b0, 5);
    chk(rk_out == 128'hd4d1c6f87c839d87caf2b8bc11f915bc, "R4 round 5 vector", rk_out, 128'hd4d1c6f87c839d87caf2b8bc11f915bc);
    read_rk(1'b0, 8);
    chk(rk_out == 128'head27321b58dbad2312bf5607f8d292f, "R4 round 8 vector", rk_out, 128'head27321b58dbad2312bf5607f8d292f);
    read_rk(1'b1, 0);
    chk(rk_out == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R6 last key first", rk_out, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b0, "R3 ready cleared by reset", 128'(ready), 128'h0);

    run_key(128'h000102030405060708090a0b0c0d0e0f);
    read_rk(1'b0, 10);
    chk(rk_out == 128'h13111d7fe3944a17f307a78b4d2b30c5, "R4 second key last round", rk_out, 128'h13111d7fe3944a17f307a78b4d2b30c5);
    run_key(128'h0);
    run_key({128{1'b1}});
    run_key({16{8'h77}});
    run_key(128'hfedcba98765432100123456789abcdef);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule